// File: doc/BRIEF.md
# Flash Page Program-Verify Sequencer

This block writes one 128-byte page of a flash array in hardware. It runs repeated program pulses, each followed by a verify pass. A host fills a local page buffer through a byte-wide write port and then pulses `start` with the page start address. Any buffer byte the host leaves unwritten holds 0xFF. The block first rejects a misaligned address. Next it reads the page once to confirm the cells are erased. After that it loops:

- Transfer 128 bytes to the array.
- Hold program-enable for a fixed number of cycles.
- Read the page back as 32 longwords. Each read follows a dummy write.

After every verify pass, a bit that must become 0 and still reads 1 is sent again. A bit that already reads 0 is masked to 1, so it receives no more pulses. The loop ends in one of three ways. It succeeds when all longwords match the target. It fails when a retry cap is reached. It times out when a watchdog expires first. Every ending restores the page buffer to all 0xFF for the next page.

Top module: `flash_page_prog`

## Requirements
- R1: Every program pass issues exactly 128 byte transfers (`fl_we` with `fl_pm` high), in ascending order at addresses `base+0` to `base+127`. Buffer bytes the host did not write are sent as 0xFF in the first pass.
- R2: A start address whose low 7 bits are not all zero (low byte other than 0x00 or 0x80) produces a one-cycle `fail` with `fail_why` = 0. No flash strobe follows.
- R3: After the 128th transfer of a pass, `fl_pe` is high for exactly PULSE_CYC consecutive cycles. It is only ever high while `fl_pm` is high.
- R4: Each longword verify read is preceded, in the previous cycle, by a dummy write of 0xFF to the same address with `fl_pv` high. Read addresses have low 2 bits 00. Byte `base+4w+k` occupies bits `8k+7:8k` of `fl_rdata`, and the data is valid the cycle after `fl_re`.
- R5: After a verify pass, the next pass sends, for each bit, 0 only where the target is 0 and the cell still reads 1. Every other bit is sent as 1.
- R6: When a verify pass finds all 32 longwords equal to the target, `done` is high for one cycle. `busy` is low from that cycle on, and the page holds the target data.
- R7: If a verify pass still mismatches after MAX_PASS program pulses, the block raises `fail` with `fail_why` = 2 and issues no further pulses.
- R8: A watchdog counts busy cycles. After exactly WDT_CYC busy cycles the block raises `timeout` for one cycle, drops `busy` and holds `fl_pe` low.
- R9: If the first read of the page finds a cell bit at 0 where the target bit is 1, the block raises `fail` with `fail_why` = 2'd1. It issues no byte transfer and no program pulse, and the page is unchanged.
- R10: At most one array mode is selected at a time: `fl_pv` is never high together with `fl_pm` or `fl_pe`.
- R11: While `busy` is high, `start` and buffer writes have no effect. The page ends with the data loaded before start, and no second operation follows.
- R12: Once an operation ends, every buffer byte reads as 0xFF again. A later shorter load therefore pads the rest of its page with 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| buf_we | input | 1 | Page buffer byte write |
| buf_idx | input | 7 | Byte offset in the page buffer |
| buf_wdata | input | 8 | Byte to store |
| start | input | 1 | Start pulse |
| page_addr | input | ADDR_W | Page start address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| fail_why | output | 2 | 0 misaligned, 1 not erased, 2 retry cap |
| timeout | output | 1 | One-cycle watchdog pulse |
| fl_we | output | 1 | Array write strobe |
| fl_re | output | 1 | Array longword read strobe |
| fl_addr | output | ADDR_W | Array byte address |
| fl_wdata | output | 8 | Array write byte |
| fl_pm | output | 1 | Program mode select |
| fl_pe | output | 1 | Program-enable pulse |
| fl_pv | output | 1 | Program-verify mode select |
| fl_rdata | input | 32 | Array read longword |

## Verification
The main function is tried on five kinds of page:

- A full 128-byte page in an erased area.
- Partial loads of 40 and 100 bytes written after a full one. These separate correct padding from stale buffer contents.
- An empty load, which must finish after the first read with no pulse.
- Pages with one stubborn byte that needs one, two or three extra pulses. These show that only that byte is re-sent, and they separate completion just inside the retry cap from failure at it.
- A page where a cell already holds 0 under a target 1, and two misaligned addresses.

Both of the last two must abort before any program activity. A second instance whose array never programs runs into the watchdog, which pins down the exact timeout cycle.

// File: rtl/flash_page_prog.sv
module flash_page_prog #(
  parameter int ADDR_W    = 16,
  parameter int PULSE_CYC = 200,
  parameter int MAX_PASS  = 999,
  parameter int WDT_CYC   = 825000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_we,
  input  logic [6:0]        buf_idx,
  input  logic [7:0]        buf_wdata,
  input  logic              start,
  input  logic [ADDR_W-1:0] page_addr,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [1:0]        fail_why,
  output logic              timeout,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_pm,
  output logic              fl_pe,
  output logic              fl_pv,
  input  logic [31:0]       fl_rdata
);
  localparam int PAGE   = 128;
  localparam int WORDS  = PAGE / 4;
  localparam int PC_W   = $clog2(PULSE_CYC + 1);
  localparam int PASS_W = $clog2(MAX_PASS + 1);
  localparam int WDT_W  = $clog2(WDT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_VWR, S_VRD, S_VCHK, S_EVAL, S_XFER, S_PULSE} st_t;
  st_t st;

  logic [7:0]        tgt [PAGE];
  logic [7:0]        rep [PAGE];
  logic [ADDR_W-1:0] base;
  logic [6:0]        bidx;
  logic [4:0]        widx;
  logic [PC_W-1:0]   pcnt;
  logic [PASS_W-1:0] passes;
  logic [WDT_W-1:0]  wdt;
  logic              pre, miss, bad;
  logic [31:0]       tword;

  wire idle    = (st == S_IDLE);
  wire aligned = (page_addr[6:0] == 7'd0);
  wire wdt_hit = !idle && (wdt == WDT_W'(WDT_CYC - 1));
  wire cap_hit = (passes == PASS_W'(MAX_PASS));
  wire ev_end  = (st == S_EVAL) && ((pre && bad) || !miss || cap_hit);
  wire clr     = wdt_hit || ev_end || (idle && start && !aligned);

  always_comb
    for (int k = 0; k < 4; k++) tword[8*k +: 8] = tgt[{widx, 2'(k)}];

  wire [31:0] rword = tword | ~fl_rdata;

  assign busy     = !idle;
  assign fl_pm    = (st == S_XFER) || (st == S_PULSE);
  assign fl_pe    = (st == S_PULSE);
  assign fl_pv    = (st == S_VWR) || (st == S_VRD) || (st == S_VCHK);
  assign fl_we    = (st == S_XFER) || (st == S_VWR);
  assign fl_re    = (st == S_VRD);
  assign fl_addr  = (st == S_XFER) ? base + ADDR_W'(bidx) : base + ADDR_W'({widx, 2'b00});
  assign fl_wdata = (st == S_XFER) ? rep[bidx] : 8'hFF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < PAGE; i++) tgt[i] <= 8'hFF;
    end else if (clr) begin
      for (int i = 0; i < PAGE; i++) tgt[i] <= 8'hFF;
    end else if (idle && buf_we) begin
      tgt[buf_idx] <= buf_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < PAGE; i++) rep[i] <= 8'hFF;
    end else if (st == S_VCHK) begin
      for (int k = 0; k < 4; k++) rep[{widx, 2'(k)}] <= rword[8*k +: 8];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; base <= '0; bidx <= '0; widx <= '0; pcnt <= '0;
      passes <= '0; wdt <= '0; pre <= 1'b0; miss <= 1'b0; bad <= 1'b0;
      done <= 1'b0; fail <= 1'b0; fail_why <= 2'd0; timeout <= 1'b0;
    end else begin
      done <= 1'b0; fail <= 1'b0; timeout <= 1'b0;
      if (wdt_hit) begin
        st <= S_IDLE; timeout <= 1'b1; wdt <= '0;
      end else begin
        if (!idle) wdt <= wdt + 1'b1;
        case (st)
          S_IDLE:
            if (start) begin
              if (aligned) begin
                base <= page_addr; pre <= 1'b1; passes <= '0; widx <= '0;
                miss <= 1'b0; bad <= 1'b0; wdt <= '0; st <= S_VWR;
              end else begin
                fail <= 1'b1; fail_why <= 2'd0;
              end
            end
          S_VWR: st <= S_VRD;
          S_VRD: st <= S_VCHK;
          S_VCHK: begin
            miss <= miss | (fl_rdata != tword);
            bad  <= bad | (|(tword & ~fl_rdata));
            if (widx == 5'(WORDS - 1)) st <= S_EVAL;
            else begin widx <= widx + 1'b1; st <= S_VWR; end
          end
          S_EVAL:
            if (pre && bad) begin
              fail <= 1'b1; fail_why <= 2'd1; st <= S_IDLE;
            end else if (!miss) begin
              done <= 1'b1; st <= S_IDLE;
            end else if (cap_hit) begin
              fail <= 1'b1; fail_why <= 2'd2; st <= S_IDLE;
            end else begin
              pre <= 1'b0; bidx <= '0; st <= S_XFER;
            end
          S_XFER: begin
            bidx <= bidx + 1'b1;
            if (bidx == 7'(PAGE - 1)) begin pcnt <= '0; st <= S_PULSE; end
          end
          S_PULSE: begin
            pcnt <= pcnt + 1'b1;
            if (pcnt == PC_W'(PULSE_CYC - 1)) begin
              passes <= passes + 1'b1; widx <= '0; miss <= 1'b0; bad <= 1'b0; st <= S_VWR;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
endmodule

module flash_page_prog_chk #(parameter int ADDR_W = 16) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              timeout,
  input logic              fl_we,
  input logic              fl_re,
  input logic              fl_pm,
  input logic              fl_pe,
  input logic              fl_pv,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [7:0]        fl_wdata
);
  // R10
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(fl_pv && (fl_pm || fl_pe)));
  // R3
  pe_in_pm_chk: assert property (@(posedge clk) disable iff (!rst_n) fl_pe |-> fl_pm);
  // R3
  pe_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(fl_pe) |-> $past(fl_we && fl_pm));
  // R4
  dummy_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_re |-> ($past(fl_we && fl_pv) && $past(fl_wdata) == 8'hFF && $past(fl_addr) == fl_addr));
  // R4
  read_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n) fl_re |-> (fl_addr[1:0] == 2'b00));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  end_report_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $onehot({done, fail, timeout}));
  // R8
  timeout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) timeout |-> (!busy && !fl_pe));
endmodule

bind flash_page_prog flash_page_prog_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail), .timeout(timeout),
  .fl_we(fl_we), .fl_re(fl_re), .fl_pm(fl_pm), .fl_pe(fl_pe), .fl_pv(fl_pv),
  .fl_addr(fl_addr), .fl_wdata(fl_wdata)
);

// File: tb/sim_flash_page_prog.sv
`timescale 1ns/1ps
module sim_flash_page_prog;
  localparam int AW = 10, PW = 4, MP = 3, WD = 20000, WD1 = 1000, STUB_OFF = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic buf_we = 1'b0, start = 1'b0, start1 = 1'b0;
  logic [6:0] buf_idx = '0;
  logic [7:0] buf_wdata = '0;
  logic [AW-1:0] page_addr = '0;
  logic [31:0] rd0 = '0;

  wire busy, done, fail, timeout, fl_we, fl_re, fl_pm, fl_pe, fl_pv;
  wire [1:0] why;
  wire [AW-1:0] fl_addr;
  wire [7:0] fl_wdata;
  wire busy1, done1, fail1, timeout1, we1, re1, pm1, pe1, pv1;
  wire [1:0] why1;
  wire [AW-1:0] addr1;
  wire [7:0] wdata1;

  flash_page_prog #(.ADDR_W(AW), .PULSE_CYC(PW), .MAX_PASS(MP), .WDT_CYC(WD)) u0 (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .start(start), .page_addr(page_addr), .busy(busy), .done(done), .fail(fail),
    .fail_why(why), .timeout(timeout), .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_pm(fl_pm), .fl_pe(fl_pe), .fl_pv(fl_pv), .fl_rdata(rd0));

  flash_page_prog #(.ADDR_W(AW), .PULSE_CYC(PW), .MAX_PASS(50), .WDT_CYC(WD1)) u1 (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .start(start1), .page_addr(page_addr), .busy(busy1), .done(done1), .fail(fail1),
    .fail_why(why1), .timeout(timeout1), .fl_we(we1), .fl_re(re1), .fl_addr(addr1),
    .fl_wdata(wdata1), .fl_pm(pm1), .fl_pe(pe1), .fl_pv(pv1), .fl_rdata(32'hFFFF_FFFF));

  // array model
  logic [7:0] mem [1024];
  logic [7:0] latch [128];
  int pulses, xfers, xfer_in_pass, order_bad, dummy_bad, pe_bad, pe_run, strobes, stub_left;
  int nonff [8];
  logic [AW-1:0] pbase = '0;
  logic pe_prev = 1'b0;

  always @(posedge clk) begin
    if (fl_we || fl_re || fl_pe) strobes++;
    if (fl_we && fl_pm) begin
      if (int'(fl_addr[6:0]) != xfer_in_pass) order_bad++;
      latch[fl_addr[6:0]] = fl_wdata;
      pbase = fl_addr & ~AW'(127);
      if (fl_wdata != 8'hFF && pulses < 8) nonff[pulses]++;
      xfer_in_pass++;
      xfers++;
    end
    if (fl_we && fl_pv && (fl_wdata != 8'hFF || fl_addr[1:0] != 2'b00)) dummy_bad++;
    if (fl_re) rd0 <= {mem[fl_addr+3], mem[fl_addr+2], mem[fl_addr+1], mem[fl_addr]};
    if (fl_pe && !pe_prev) begin
      pulses++;
      xfer_in_pass = 0;
      for (int i = 0; i < 128; i++)
        if (!(i == STUB_OFF && stub_left > 0)) mem[pbase + AW'(i)] = mem[pbase + AW'(i)] & latch[i];
      if (stub_left > 0) stub_left--;
    end
    if (fl_pe) pe_run++;
    else if (pe_prev) begin
      if (pe_run != PW) pe_bad++;
      pe_run = 0;
    end
    pe_prev = fl_pe;
  end

  int nchk = 0, nfail = 0, cyc_all = 0;

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all == 150000) begin
      nfail++;
      $display("FAIL R6 bench watchdog expired act=%0d exp=%0d", cyc_all, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // addr[39:30] n[29:22] seed[21:14] stub[13:10] pre[9] exp[8:6] ign[5]
  // exp: 0 done, 1 misaligned, 2 not erased, 3 retry cap
  localparam logic [39:0] VEC [8] = '{
    {10'h000, 8'd128, 8'h3C, 4'd0, 1'b0, 3'd0, 1'b0, 5'd0},
    {10'h080, 8'd40,  8'h5A, 4'd1, 1'b0, 3'd0, 1'b1, 5'd0},
    {10'h100, 8'd100, 8'h11, 4'd2, 1'b0, 3'd0, 1'b0, 5'd0},
    {10'h180, 8'd128, 8'h77, 4'd3, 1'b0, 3'd3, 1'b0, 5'd0},
    {10'h200, 8'd0,   8'h00, 4'd0, 1'b0, 3'd0, 1'b0, 5'd0},
    {10'h240, 8'd16,  8'h22, 4'd0, 1'b0, 3'd1, 1'b0, 5'd0},
    {10'h281, 8'd16,  8'h33, 4'd0, 1'b0, 3'd1, 1'b0, 5'd0},
    {10'h300, 8'd64,  8'h99, 4'd0, 1'b1, 3'd2, 1'b0, 5'd0}
  };

  task automatic run_vec(input logic [39:0] v);
    logic [AW-1:0] addr, pg;
    int n, stub, expo, got, cyc, exp_p, bad_m, bad_pad, nff, extra_busy;
    logic [7:0] seed, t;
    logic [7:0] et [128];
    bit pre, ign;
    addr = v[39:30]; n = int'(v[29:22]); seed = v[21:14]; stub = int'(v[13:10]);
    pre = v[9]; expo = int'(v[8:6]); ign = v[5];
    pg = addr & ~AW'(127);
    for (int i = 0; i < 128; i++) mem[pg + AW'(i)] = 8'hFF;
    if (pre) mem[pg + 3] = 8'h00;
    nff = 0;
    for (int i = 0; i < 128; i++) begin
      t = 8'hFF;
      if (i < n) begin
        t = (seed + 8'(i * 29)) ^ 8'(i << 1);
        if (i == STUB_OFF) t = t & 8'h7E;
        if (pre && i == 3) t = 8'hF0;
      end
      et[i] = t;
      if (t != 8'hFF) nff++;
    end
    pulses = 0; xfers = 0; xfer_in_pass = 0; strobes = 0; stub_left = stub;
    for (int i = 0; i < 8; i++) nonff[i] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); buf_we = 1'b1; buf_idx = 7'(i); buf_wdata = et[i];
    end
    @(negedge clk); buf_we = 1'b0; start = 1'b1; page_addr = addr;
    @(negedge clk); start = 1'b0;
    if (ign) begin
      repeat (50) @(negedge clk);
      buf_we = 1'b1; buf_idx = 7'd0; buf_wdata = 8'h00; start = 1'b1;
      @(negedge clk); buf_we = 1'b0; start = 1'b0;
    end
    cyc = 0;
    while (!(done || fail || timeout) && cyc < 5000) begin @(negedge clk); cyc++; end
    got = done ? 0 : (fail ? int'(why) + 1 : (timeout ? 4 : 5));
    chk(got == expo, (expo == 0) ? "R6 outcome" : (expo == 1) ? "R2 outcome" : (expo == 2) ? "R9 outcome" : "R7 outcome", got, expo);
    @(negedge clk);
    chk(!done && !busy, "R6 single-cycle end", {done, busy}, 0);
    exp_p = (expo == 3) ? MP : (expo == 0 && nff > 0) ? stub + 1 : 0;
    chk(pulses == exp_p, "R7 program pulse count", pulses, exp_p);
    chk(xfers == exp_p * 128, "R1 transfers per pass", xfers, exp_p * 128);
    if (expo == 1) chk(strobes == 0, "R2 no flash access", strobes, 0);
    if (expo == 2) begin
      chk(xfers == 0 && pulses == 0, "R9 no program activity", xfers + pulses, 0);
      chk(mem[pg + 3] == 8'h00 && mem[pg + 4] == 8'hFF, "R9 page unchanged", {mem[pg + 3], mem[pg + 4]}, 16'h00FF);
    end
    if (exp_p > 0) chk(nonff[0] == nff, "R1 first pass padding", nonff[0], nff);
    if (exp_p > 1) chk(nonff[1] == 1, "R5 only stubborn byte resent", nonff[1], 1);
    if (expo == 0) begin
      bad_m = 0; bad_pad = 0;
      for (int i = 0; i < 128; i++)
        if (mem[pg + AW'(i)] != et[i]) begin if (i < n) bad_m++; else bad_pad++; end
      chk(bad_m == 0, "R6 page holds target", bad_m, 0);
      chk(bad_pad == 0, "R12 unloaded bytes stay 0xFF", bad_pad, 0);
    end
    if (ign) begin
      extra_busy = 0;
      repeat (300) begin @(negedge clk); if (busy) extra_busy++; end
      chk(extra_busy == 0, "R11 start while busy ignored", extra_busy, 0);
      chk(mem[pg] == et[0], "R11 buffer write while busy ignored", mem[pg], et[0]);
    end
  endtask

  initial begin
    int bcnt, seen;
    for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
    pulses = 0; xfers = 0; xfer_in_pass = 0; order_bad = 0; dummy_bad = 0;
    pe_bad = 0; pe_run = 0; strobes = 0; stub_left = 0;
    repeat (3) @(negedge clk);
    chk({busy, done, fail, timeout, fl_we, fl_re, fl_pm, fl_pe, fl_pv} == '0, "R10 reset state",
        {busy, done, fail, timeout, fl_we, fl_re, fl_pm, fl_pe, fl_pv}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 8; k++) run_vec(VEC[k]);
    chk(order_bad == 0, "R1 ascending transfer order", order_bad, 0);
    chk(dummy_bad == 0, "R4 dummy write value and alignment", dummy_bad, 0);
    chk(pe_bad == 0, "R3 program pulse width", pe_bad, 0);

    // watchdog on the second instance, whose array never programs
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); buf_we = 1'b1; buf_idx = 7'(i); buf_wdata = 8'h00;
    end
    @(negedge clk); buf_we = 1'b0; page_addr = '0; start1 = 1'b1;
    @(negedge clk); start1 = 1'b0;
    bcnt = 0; seen = 0;
    for (int c = 0; c < 1500 && seen == 0; c++) begin
      if (busy1) bcnt++;
      if (timeout1) seen = 1;
      else @(negedge clk);
    end
    chk(seen == 1, "R8 timeout raised", seen, 1);
    chk(bcnt == WD1, "R8 busy cycles before timeout", bcnt, WD1);
    chk(!pe1 && !busy1 && !done1 && !fail1, "R8 quiet after timeout", {pe1, busy1, done1, fail1}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule